// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one mouse event into a five-byte serial mouse packet and places the bytes in a small receive queue. An event is a single-cycle strobe that carries a signed horizontal delta, a signed vertical delta and three button levels. A consumer reads the queue one byte at a time, and a receive-available flag tells it that data is waiting.

The first byte is a sync header in which pressed buttons read as zero. It is followed by the horizontal delta, the negated vertical delta and two zero pad bytes. Both deltas are clamped to the symmetric range -127..+127. The encoder offers each byte to the queue on consecutive cycles. A byte that meets a full queue is lost and nothing reports it. A strobe that arrives while a packet is still going out has no effect.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: The header byte is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared when the middle button is pressed and bit 0 cleared when the right button is pressed. Bit 7 is always 1 and bits 6..3 are always 0.
- R2: The second byte is the horizontal delta clamped to -127..+127 in 8-bit two's complement. Values above +127 give 0x7F and values below -127 give 0x81.
- R3: The third byte is the negated vertical delta, clamped the same way. Vertical +5 gives 0xFB, and vertical -128 or lower gives 0x7F.
- R4: The fourth and fifth bytes are always 0x00.
- R5: A strobe seen while idle is captured at that clock edge. `busy` is high for the next five cycles, and the bytes enter the queue in the order header, horizontal, vertical, pad, pad, one per cycle.
- R6: A strobe while `busy` is high is ignored and queues no bytes. The captured values of the packet in flight are not changed.
- R7: A byte offered while `fillCount` equals DEPTH is discarded. `fillCount` never exceeds DEPTH, and the bytes already queued are kept.
- R8: `rxAvail` is high exactly when `fillCount` is nonzero. `rdData` shows the oldest byte, and `rdEn` removes it. `rdEn` on an empty queue has no effect.
- R9: The queue pointers wrap at DEPTH even when DEPTH is not a power of two, and the first-in first-out order holds across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe | input | 1 | One-cycle mouse event strobe |
| dxIn | input | DELTA_W | Signed horizontal delta |
| dyIn | input | DELTA_W | Signed vertical delta |
| btnLeft | input | 1 | Left button pressed (active high) |
| btnMid | input | 1 | Middle button pressed (active high) |
| btnRight | input | 1 | Right button pressed (active high) |
| busy | output | 1 | Packet bytes are being emitted |
| rdEn | input | 1 | Remove the oldest queued byte |
| rdData | output | 8 | Oldest queued byte |
| rxAvail | output | 1 | Queue holds at least one byte |
| fillCount | output | $clog2(DEPTH+1) | Number of queued bytes |

## Verification
The bench builds the block with DELTA_W = 10 and DEPTH = 6. A queue of six is not a power of two, so the pointer wrap is exercised: draining one packet after another moves the pointers past the end within a few packets. The same depth is only one byte larger than a packet, so a second packet sent without a drain overflows the queue after its header, which exercises the drop rule. The ten-bit deltas reach well past both clamp limits, including the most negative value, whose negation is the case most likely to break the vertical clamp.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;

  localparam int PKT_LEN = 5;

  typedef enum logic [2:0] {
    SEL_HDR  = 3'd0,
    SEL_DX   = 3'd1,
    SEL_DY   = 3'd2,
    SEL_PAD0 = 3'd3,
    SEL_PAD1 = 3'd4
  } byteSel_t;

  typedef struct packed {
    logic     capture;
    logic     push;
    byteSel_t sel;
  } ctrlStrobes_t;

endpackage

// File: rtl/mouse_pkt_ctrl.sv
module mouse_pkt_ctrl
  import mouse_pkt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtStrobe,
  output ctrlStrobes_t strb,
  output logic         busy
);

  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  localparam logic [2:0] LAST_IDX = 3'(PKT_LEN - 1);

  state_t     state;
  logic [2:0] byteIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          byteIdx <= '0;
          if (evtStrobe) state <= ST_SEND;
        end
        default: begin
          if (byteIdx == LAST_IDX) begin
            state   <= ST_IDLE;
            byteIdx <= '0;
          end else begin
            byteIdx <= byteIdx + 3'd1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.capture = (state == ST_IDLE) && evtStrobe;
    strb.push    = (state == ST_SEND);
    strb.sel     = byteSel_t'(byteIdx);
    busy         = (state == ST_SEND);
  end

  // R5: a capture is followed by the header push
  assert_capture_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (strb.push && strb.sel == SEL_HDR));

  // R5: bytes advance one per cycle until the last
  assert_push_seq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.sel != SEL_PAD1) |=> (strb.push && strb.sel == byteSel_t'($past(strb.sel) + 3'd1)));

  // R6: a strobe during a packet never restarts it
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && evtStrobe && strb.sel != SEL_PAD1) |=> (strb.sel != SEL_HDR));

endmodule

// File: rtl/mouse_pkt_datapath.sv
module mouse_pkt_datapath
  import mouse_pkt_pkg::*;
#(
  parameter int DELTA_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [DELTA_W-1:0] dxIn,
  input  logic [DELTA_W-1:0] dyIn,
  input  logic               btnLeft,
  input  logic               btnMid,
  input  logic               btnRight,
  output logic               wrValid,
  output logic [7:0]         wrByte
);

  localparam int EXT_W = DELTA_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(127);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -EXT_W'(127);

  logic signed [EXT_W-1:0] dxExt, dyNeg;
  logic [7:0] dxSat, dySat, hdrNext;
  logic [7:0] hdrReg, dxReg, dyReg;

  always_comb begin
    dxExt = EXT_W'($signed(dxIn));
    dyNeg = -EXT_W'($signed(dyIn));
    if (dxExt > POS_LIM)      dxSat = 8'h7F;
    else if (dxExt < NEG_LIM) dxSat = 8'h81;
    else                      dxSat = dxExt[7:0];
    if (dyNeg > POS_LIM)      dySat = 8'h7F;
    else if (dyNeg < NEG_LIM) dySat = 8'h81;
    else                      dySat = dyNeg[7:0];
    hdrNext = {5'b10000, ~btnLeft, ~btnMid, ~btnRight};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrReg <= 8'h87;
      dxReg  <= '0;
      dyReg  <= '0;
    end else if (strb.capture) begin
      hdrReg <= hdrNext;
      dxReg  <= dxSat;
      dyReg  <= dySat;
    end
  end

  always_comb begin
    wrValid = strb.push;
    case (strb.sel)
      SEL_HDR: wrByte = hdrReg;
      SEL_DX:  wrByte = dxReg;
      SEL_DY:  wrByte = dyReg;
      default: wrByte = 8'h00;
    endcase
  end

  // R1: header keeps its sync pattern
  assert_hdr_sync_R1: assert property (@(posedge clk) disable iff (!rstN)
    hdrReg[7:3] == 5'b10000);

  // R2: clamped horizontal never reaches -128
  assert_dx_sat_R2: assert property (@(posedge clk) disable iff (!rstN)
    dxReg != 8'h80);

  // R3: clamped vertical never reaches -128
  assert_dy_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    dyReg != 8'h80);

  // R6: captured values hold while a packet is out
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && $past(strb.push)) |-> ($stable(hdrReg) && $stable(dxReg) && $stable(dyReg)));

endmodule

// File: rtl/mouse_pkt_fifo.sv
module mouse_pkt_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic [7:0]                 wrByte,
  input  logic                       rdEn,
  output logic [7:0]                 rdData,
  output logic                       rxAvail,
  output logic [$clog2(DEPTH+1)-1:0] fillCount
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  always_comb begin
    doPush = wrValid && (count != FULL_CNT);
    doPop  = rdEn && (count != '0);
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    rdData    = mem[rdPtr];
    rxAvail   = (count != '0);
    fillCount = count;
  end

  // R7: occupancy bounded by the depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R7: an offer into a full queue without a read leaves it full
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && count == FULL_CNT && !rdEn) |=> (count == FULL_CNT));

  // R8: a stored byte raises the available flag
  assert_avail_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !rdEn) |=> rxAvail);

  // R8: reading an empty queue does nothing
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && count == '0 && !wrValid) |=> (count == '0));

  // R9: pointers stay inside the depth
  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= LAST_PTR) && (rdPtr <= LAST_PTR));

endmodule

// File: rtl/mouse_pkt_encoder.sv
module mouse_pkt_encoder
  import mouse_pkt_pkg::*;
#(
  parameter int DELTA_W = 10,
  parameter int DEPTH   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       evtStrobe,
  input  logic [DELTA_W-1:0]         dxIn,
  input  logic [DELTA_W-1:0]         dyIn,
  input  logic                       btnLeft,
  input  logic                       btnMid,
  input  logic                       btnRight,
  output logic                       busy,
  input  logic                       rdEn,
  output logic [7:0]                 rdData,
  output logic                       rxAvail,
  output logic [$clog2(DEPTH+1)-1:0] fillCount
);

  ctrlStrobes_t strb;
  logic         wrValid;
  logic [7:0]   wrByte;

  mouse_pkt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .evtStrobe(evtStrobe), .strb(strb), .busy(busy)
  );

  mouse_pkt_datapath #(.DELTA_W(DELTA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .dxIn(dxIn), .dyIn(dyIn),
    .btnLeft(btnLeft), .btnMid(btnMid), .btnRight(btnRight),
    .wrValid(wrValid), .wrByte(wrByte)
  );

  mouse_pkt_fifo #(.DEPTH(DEPTH)) uFifo (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte),
    .rdEn(rdEn), .rdData(rdData), .rxAvail(rxAvail), .fillCount(fillCount)
  );

endmodule

// File: tb/tb_mouse_pkt_encoder.sv
`timescale 1ns/1ps
module tb_mouse_pkt_encoder;

  localparam int DELTA_W = 10;
  localparam int DEPTH   = 6;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtStrobe = 1'b0;
  logic [DELTA_W-1:0] dxIn = '0, dyIn = '0;
  logic btnLeft = 1'b0, btnMid = 1'b0, btnRight = 1'b0;
  logic busy, rxAvail;
  logic rdEnMon = 1'b0, rdEnMan = 1'b0;
  logic [7:0] rdData;
  logic [CNT_W-1:0] fillCount;

  int checks = 0;
  int fails = 0;
  int modelCnt = 0;
  bit drainOn = 1'b0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  mouse_pkt_encoder #(.DELTA_W(DELTA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .evtStrobe(evtStrobe), .dxIn(dxIn), .dyIn(dyIn),
    .btnLeft(btnLeft), .btnMid(btnMid), .btnRight(btnRight), .busy(busy),
    .rdEn(rdEnMon | rdEnMan), .rdData(rdData), .rxAvail(rxAvail), .fillCount(fillCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] clampByte(input int v);
    int c;
    c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return c[7:0];
  endfunction

  function automatic void expectByte(input logic [7:0] v, input string tag);
    expItem_t it;
    if (modelCnt < DEPTH) begin
      it.val = v;
      it.tag = tag;
      expQ.push_back(it);
      modelCnt++;
    end
  endfunction

  // driver: one event, expected bytes go to the scoreboard
  task automatic sendEvt(input int dx, input int dy, input bit l, input bit m, input bit r);
    @(negedge clk);
    dxIn = DELTA_W'(dx);
    dyIn = DELTA_W'(dy);
    btnLeft = l; btnMid = m; btnRight = r;
    evtStrobe = 1'b1;
    expectByte({5'b10000, ~l, ~m, ~r}, "R1 header");
    expectByte(clampByte(dx), "R2 horizontal");
    expectByte(clampByte(-dy), "R3 vertical");
    expectByte(8'h00, "R4 pad0");
    expectByte(8'h00, "R4 pad1");
    @(negedge clk);
    evtStrobe = 1'b0;
    check(busy == 1'b1, "R5 busy after capture", busy, 1);
  endtask

  task automatic waitIdle();
    repeat (6) @(negedge clk);
    check(busy == 1'b0, "R5 busy ends after five bytes", busy, 0);
  endtask

  task automatic drain();
    drainOn = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (expQ.size() == 0 && !rxAvail) break;
    end
    drainOn = 1'b0;
    check(expQ.size() == 0, "R8 all expected bytes read", expQ.size(), 0);
    check(fillCount == 0 && !rxAvail, "R8 empty after drain", fillCount, 0);
    expQ.delete();
    modelCnt = 0;
  endtask

  // monitor: pops the scoreboard as bytes appear
  always @(negedge clk) begin
    rdEnMon = 1'b0;
    if (drainOn && rxAvail) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected byte", rdData, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(rdData == it.val, it.tag, rdData, it.val);
        modelCnt--;
      end
      rdEnMon = 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R5 reset busy", busy, 0);
    check(rxAvail == 1'b0, "R8 reset rxAvail", rxAvail, 0);
    check(fillCount == 0, "R8 reset fillCount", fillCount, 0);

    // R8: read on empty queue
    rdEnMan = 1'b1;
    @(negedge clk);
    rdEnMan = 1'b0;
    @(negedge clk);
    check(fillCount == 0 && !rxAvail, "R8 empty read ignored", fillCount, 0);

    // basic packet, left pressed
    sendEvt(5, 3, 1, 0, 0);
    waitIdle();
    check(fillCount == 5 && rxAvail, "R5 five bytes queued", fillCount, 5);
    drain();

    // clamp beyond limits, R2 R3
    sendEvt(300, -300, 0, 0, 0);  waitIdle(); drain();
    sendEvt(-300, 200, 1, 1, 1);  waitIdle(); drain();
    sendEvt(127, -127, 0, 1, 1);  waitIdle(); drain();
    sendEvt(-128, 128, 0, 1, 0);  waitIdle(); drain();
    sendEvt(-512, -512, 0, 0, 1); waitIdle(); drain();
    sendEvt(511, 5, 1, 0, 1);     waitIdle(); drain();

    // R6: strobe held while busy with other data
    sendEvt(10, -20, 0, 0, 0);
    dxIn = DELTA_W'(99); dyIn = DELTA_W'(99); btnLeft = 1'b1;
    evtStrobe = 1'b1;
    repeat (3) @(negedge clk);
    evtStrobe = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R6 no restart after ignored strobe", busy, 0);
    check(fillCount == 5, "R6 ignored strobe queues nothing", fillCount, 5);
    drain();

    // R7: overflow, second packet keeps header only
    sendEvt(1, 1, 0, 0, 0); waitIdle();
    sendEvt(2, 2, 1, 1, 0); waitIdle();
    check(fillCount == DEPTH, "R7 full count held at depth", fillCount, DEPTH);
    drain();

    // R9: several more packets across pointer wraps
    for (int k = 0; k < 4; k++) begin
      sendEvt(k * 7 - 9, 40 - k * 30, k[0], k[1], 1'b0);
      waitIdle();
      drain();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule